// File: doc/BRIEF.md
# Tree Network Routing Decision Unit

This block makes the per-hop exit decision for a message header travelling through a binary-tree interconnect whose node addresses are variable-length bit strings. The root carries the one-bit address `1`. Each child extends its parent's string by one bit: `0` for the left child, `1` for the right child. A header arrives with a target address and its valid length. The node supplies its own address and length, whether it sits at the frontier of the tree, and which of its three links (parent, left child, right child) can currently accept traffic. From these inputs alone the block picks one exit: up, left, right, or local delivery.

Addresses are stored left-aligned, so the first bit of the string sits in the most significant position, and only the first `len` bits are meaningful. A header marked as bound for a leaf may name a node that has since grown children. Such a header keeps moving down through left children until a node that knows it is a leaf takes it. When the preferred link is blocked, the block takes another link and adds one to the detour count carried in the header. A message that has used up its detour allowance, or that has no usable link at all, is flagged for purge and handed to the local controller, which sends a notice back to the sender.

The decision is registered. A header accepted on a clock edge produces its decision in the following cycle, behind a valid/ready handshake.

Top module: `tree_route_unit`

## Requirements
- R1: After reset, `dec_valid` is 0 and `hdr_ready` is 1.
- R2: If the local address is longer than the target, or its first `local_len` bits differ from the target's, the primary exit is up. The exit encoding is 0 local, 1 up, 2 left, 3 right.
- R3: If the local address is a strict prefix of the target, the primary exit is down. The target bit directly after the prefix selects the child: 0 gives left (2), 1 gives right (3).
- R4: If the lengths are equal and the bits match, the primary exit is local (0). The exception is a header with `leaf_msg`=1 at a node with `local_is_leaf`=0, whose primary exit is left (2).
- R5: `link_ok` bit 0 is the parent link, bit 1 the left link and bit 2 the right link. If the primary link's bit is 0, the exit becomes the first available link other than the primary, in the order up, left, right, and `dec_detour` becomes `detour_in`+1, saturating at 255.
- R6: `dec_purge` is 1, with exit local (0) and `dec_detour` = `detour_in`, when the primary link is blocked and no other link is available. `dec_purge` is also 1, with exit local, when a detour is taken and the incremented count is at least `detour_limit`. In all other cases it is 0.
- R7: When the primary exit is local or its link is available, `dec_detour` equals `detour_in` and `dec_purge` is 0.
- R8: A header accepted when `hdr_valid` and `hdr_ready` are both high produces its decision with `dec_valid`=1 in the next cycle. `hdr_ready` equals `!dec_valid || dec_ready`. While `dec_ready` is low, the decision is held unchanged.
- R9: Address bits beyond the stated length of either address have no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hdr_valid | input | 1 | A header is presented |
| hdr_ready | output | 1 | The unit can accept a header |
| local_addr | input | ADDR_W | This node's address, left-aligned |
| local_len | input | LEN_W | Number of valid bits in `local_addr` |
| local_is_leaf | input | 1 | This node has no children |
| tgt_addr | input | ADDR_W | Target node address, left-aligned |
| tgt_len | input | LEN_W | Number of valid bits in `tgt_addr` |
| leaf_msg | input | 1 | Header is bound for a leaf node |
| detour_in | input | 8 | Detour count carried by the header |
| detour_limit | input | 8 | Detour allowance before purge |
| link_ok | input | 3 | Link availability: bit0 up, bit1 left, bit2 right |
| dec_valid | output | 1 | A decision is held |
| dec_ready | input | 1 | The consumer takes the decision |
| dec_exit | output | 2 | Chosen exit: 0 local, 1 up, 2 left, 3 right |
| dec_detour | output | 8 | Updated detour count |
| dec_purge | output | 1 | Purge the message and notify the sender |

## Verification
The bench uses a five-bit address width and crosses every node of a four-level tree as the local position with every node as the target. The expected exit is computed from heap node numbers: a node's children are 2n and 2n+1. With both leaf flags swept, this pass separates the up, left-child, right-child and local outcomes, including the case where a leaf-bound header continues leftward. Junk bits placed below each address's length show that only the stated prefix is compared. A second pass walks every link-availability mask with detour counts below the limit, at the limit and at saturation. This separates a plain detour from a purge caused by an exhausted allowance and from a purge caused by having no link at all. A stall sequence shows that a held decision stays unchanged and that a new header waits until the held decision is taken.

// File: rtl/tru_pkg.sv
package tru_pkg;

  localparam int DETOUR_W = 8;

  typedef logic [DETOUR_W-1:0] detour_t;

  typedef enum logic [1:0] {
    EXIT_LOCAL = 2'd0,
    EXIT_UP    = 2'd1,
    EXIT_LEFT  = 2'd2,
    EXIT_RIGHT = 2'd3
  } exit_e;

  typedef struct packed {
    logic  found;
    exit_e dir;
  } alt_t;

  typedef struct packed {
    exit_e   exit_dir;
    logic    purge;
    detour_t detour;
  } decision_t;

  // Bit of link_ok that belongs to a non-local exit
  function automatic logic [1:0] link_idx(exit_e d);
    return 2'(d) - 2'd1;
  endfunction

  // Saturating increment of the detour count
  function automatic detour_t sat_inc(detour_t c);
    return (c == '1) ? c : c + detour_t'(1);
  endfunction

  // First usable link other than the primary, in the order up, left, right
  function automatic alt_t pick_alt(exit_e prim, logic [2:0] ok);
    alt_t r;
    r.found = 1'b0;
    r.dir   = EXIT_LOCAL;
    for (int i = 2; i >= 0; i--) begin
      if (ok[i] && (exit_e'(i + 1) != prim)) begin
        r.found = 1'b1;
        r.dir   = exit_e'(i + 1);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/tru_prefix_cmp.sv
module tru_prefix_cmp #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = $clog2(ADDR_W + 1)
) (
  input  logic [ADDR_W-1:0] local_addr,
  input  logic [LEN_W-1:0]  local_len,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [LEN_W-1:0]  tgt_len,
  output logic              is_prefix,
  output logic              is_exact,
  output logic              next_bit
);

  // Ones in the top 'len' positions of a left-aligned address
  function automatic logic [ADDR_W-1:0] lead_mask(logic [LEN_W-1:0] len);
    return ~({ADDR_W{1'b1}} >> len);
  endfunction

  logic [ADDR_W-1:0] diff_bits;
  logic [ADDR_W-1:0] tgt_shifted;

  always_comb begin
    diff_bits   = (local_addr ^ tgt_addr) & lead_mask(local_len);
    tgt_shifted = tgt_addr << local_len;
    is_prefix   = (local_len <= tgt_len) && (diff_bits == '0);
    is_exact    = is_prefix && (local_len == tgt_len);
    next_bit    = tgt_shifted[ADDR_W-1];
  end

endmodule

// File: rtl/tru_dir_select.sv
module tru_dir_select
  import tru_pkg::*;
(
  input  logic      is_prefix,
  input  logic      is_exact,
  input  logic      next_bit,
  input  logic      leaf_msg,
  input  logic      local_is_leaf,
  input  logic [2:0] link_ok,
  input  detour_t   detour_in,
  input  detour_t   detour_limit,
  output exit_e     primary,
  output logic      detoured,
  output logic      no_route,
  output decision_t dec
);

  logic    prim_ok;
  alt_t    alt;
  detour_t bumped;
  logic    over_limit;

  always_comb begin
    if (!is_prefix)
      primary = EXIT_UP;
    else if (!is_exact)
      primary = next_bit ? EXIT_RIGHT : EXIT_LEFT;
    else
      primary = (leaf_msg && !local_is_leaf) ? EXIT_LEFT : EXIT_LOCAL;

    prim_ok    = (primary == EXIT_LOCAL) || link_ok[link_idx(primary)];
    alt        = pick_alt(primary, link_ok);
    detoured   = !prim_ok && alt.found;
    no_route   = !prim_ok && !alt.found;
    bumped     = sat_inc(detour_in);
    over_limit = detoured && (bumped >= detour_limit);

    dec.purge    = no_route || over_limit;
    dec.detour   = detoured ? bumped : detour_in;
    if (dec.purge)
      dec.exit_dir = EXIT_LOCAL;
    else if (prim_ok)
      dec.exit_dir = primary;
    else
      dec.exit_dir = alt.dir;
  end

endmodule

// File: rtl/tru_out_reg.sv
module tru_out_reg #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_pay
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pay   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_pay <= in_pay;
    end
  end

endmodule

// File: rtl/tree_route_unit.sv
module tree_route_unit
  import tru_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [ADDR_W-1:0] local_addr,
  input  logic [LEN_W-1:0]  local_len,
  input  logic              local_is_leaf,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [LEN_W-1:0]  tgt_len,
  input  logic              leaf_msg,
  input  logic [7:0]        detour_in,
  input  logic [7:0]        detour_limit,
  input  logic [2:0]        link_ok,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic [1:0]        dec_exit,
  output logic [7:0]        dec_detour,
  output logic              dec_purge
);

  localparam int PAY_W = $bits(decision_t);

  logic      is_prefix;
  logic      is_exact;
  logic      next_bit;
  exit_e     primary;
  logic      detoured;
  logic      no_route;
  decision_t dec_next;
  decision_t dec_q;

  tru_prefix_cmp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cmp (
    .local_addr (local_addr),
    .local_len  (local_len),
    .tgt_addr   (tgt_addr),
    .tgt_len    (tgt_len),
    .is_prefix  (is_prefix),
    .is_exact   (is_exact),
    .next_bit   (next_bit)
  );

  tru_dir_select u_sel (
    .is_prefix     (is_prefix),
    .is_exact      (is_exact),
    .next_bit      (next_bit),
    .leaf_msg      (leaf_msg),
    .local_is_leaf (local_is_leaf),
    .link_ok       (link_ok),
    .detour_in     (detour_in),
    .detour_limit  (detour_limit),
    .primary       (primary),
    .detoured      (detoured),
    .no_route      (no_route),
    .dec           (dec_next)
  );

  tru_out_reg #(.PAY_W(PAY_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (hdr_valid),
    .in_ready  (hdr_ready),
    .in_pay    (dec_next),
    .out_valid (dec_valid),
    .out_ready (dec_ready),
    .out_pay   (dec_q)
  );

  assign dec_exit   = 2'(dec_q.exit_dir);
  assign dec_detour = dec_q.detour;
  assign dec_purge  = dec_q.purge;

endmodule

// File: rtl/tru_checker.sv
module tru_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       hdr_valid,
  input logic       hdr_ready,
  input logic [2:0] link_ok,
  input logic [7:0] detour_in,
  input logic       dec_valid,
  input logic       dec_ready,
  input logic [1:0] dec_exit,
  input logic [7:0] dec_detour,
  input logic       dec_purge,
  input logic       detoured,
  input logic       no_route
);

  logic accept;
  assign accept = hdr_valid && hdr_ready;

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> dec_valid); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_exit) && $stable(dec_detour) && $stable(dec_purge))); // R8

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> hdr_ready); // R8

  AST_PURGE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_purge) |-> (dec_exit == 2'd0)); // R6

  AST_DETOUR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((dec_detour == $past(detour_in)) || (dec_detour == $past(detour_in) + 8'd1))); // R5

  AST_ALL_LINKS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && link_ok == 3'b111) |=> (dec_detour == $past(detour_in) && !dec_purge)); // R7

  AST_NO_ROUTE_PURGES: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && no_route) |=> (dec_purge && dec_detour == $past(detour_in))); // R6

  AST_DETOUR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(detoured && no_route)); // R5

endmodule

bind tree_route_unit tru_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hdr_valid  (hdr_valid),
  .hdr_ready  (hdr_ready),
  .link_ok    (link_ok),
  .detour_in  (detour_in),
  .dec_valid  (dec_valid),
  .dec_ready  (dec_ready),
  .dec_exit   (dec_exit),
  .dec_detour (dec_detour),
  .dec_purge  (dec_purge),
  .detoured   (detoured),
  .no_route   (no_route)
);

// File: tb/tree_route_unit_tb.sv
`timescale 1ns/1ps
module tree_route_unit_tb;

  localparam int AW = 5;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hdr_valid = 1'b0;
  logic          hdr_ready;
  logic [AW-1:0] local_addr = '0;
  logic [LW-1:0] local_len = '0;
  logic          local_is_leaf = 1'b0;
  logic [AW-1:0] tgt_addr = '0;
  logic [LW-1:0] tgt_len = '0;
  logic          leaf_msg = 1'b0;
  logic [7:0]    detour_in = '0;
  logic [7:0]    detour_limit = '0;
  logic [2:0]    link_ok = '0;
  logic          dec_valid;
  logic          dec_ready = 1'b1;
  logic [1:0]    dec_exit;
  logic [7:0]    dec_detour;
  logic          dec_purge;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tree_route_unit #(.ADDR_W(AW), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .local_addr(local_addr), .local_len(local_len), .local_is_leaf(local_is_leaf),
    .tgt_addr(tgt_addr), .tgt_len(tgt_len), .leaf_msg(leaf_msg),
    .detour_in(detour_in), .detour_limit(detour_limit), .link_ok(link_ok),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_exit(dec_exit),
    .dec_detour(dec_detour), .dec_purge(dec_purge)
  );

  function automatic int nlen(int n);
    int k = 0;
    while (n > 0) begin k++; n = n >> 1; end
    return k;
  endfunction

  // Heap-numbered node n: left-aligned bits plus junk below the length
  function automatic logic [AW-1:0] enc(int n, int junk);
    int len = nlen(n);
    int low = junk & ((1 << (AW - len)) - 1);
    return AW'((n << (AW - len)) | low);
  endfunction

  function automatic int prim_of(int l, int t, bit lm, bit il);
    int ll = nlen(l);
    int tl = nlen(t);
    if (tl >= ll && (t >> (tl - ll)) == l) begin
      if (tl == ll) return (lm && !il) ? 2 : 0;
      return ((t >> (tl - ll - 1)) & 1) ? 3 : 2;
    end
    return 1;
  endfunction

  // Returns {exit[1:0], purge, detour[7:0]}
  function automatic logic [10:0] expect_dec(int prim, logic [2:0] ok, int din, int lim);
    int alt = 0;
    int nd;
    if (prim == 0 || ok[prim-1]) return {2'(prim), 1'b0, 8'(din)};
    for (int d = 3; d >= 1; d--) if (d != prim && ok[d-1]) alt = d;
    if (alt == 0) return {2'd0, 1'b1, 8'(din)};
    nd = (din == 255) ? 255 : din + 1;
    if (nd >= lim) return {2'd0, 1'b1, 8'(nd)};
    return {2'(alt), 1'b0, 8'(nd)};
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual={valid,exit,purge,detour}=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(int l, int t, bit lm, bit il, logic [2:0] ok,
                         int din, int lim, string tag);
    logic [10:0] e;
    @(negedge clk);
    local_addr = enc(l, l * 7 + t * 3);
    local_len = LW'(nlen(l));
    tgt_addr = enc(t, t * 5 + 1);
    tgt_len = LW'(nlen(t));
    leaf_msg = lm; local_is_leaf = il; link_ok = ok;
    detour_in = 8'(din); detour_limit = 8'(lim);
    hdr_valid = 1'b1; dec_ready = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    e = expect_dec(prim_of(l, t, lm, il), ok, din, lim);
    check(tag, {dec_valid, dec_exit, dec_purge, dec_detour}, {1'b1, e});
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {dec_valid, hdr_ready, 10'd0}, {1'b0, 1'b1, 10'd0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {dec_valid, hdr_ready, 10'd0}, {1'b0, 1'b1, 10'd0});

    // Primary routing sweep over all node pairs, all links up, junk low bits (R9)
    for (int l = 1; l < 16; l++)
      for (int t = 1; t < 16; t++)
        for (int f = 0; f < 4; f++) begin
          int p = prim_of(l, t, f[0], f[1]);
          string tg;
          if (p == 1) tg = "R2 R9 up";
          else if (nlen(l) == nlen(t)) tg = "R4 R9 exact";
          else tg = "R3 R9 down";
          run_one(l, t, f[0], f[1], 3'b111, t % 4, 8, tg);
        end

    // Link availability sweep with detour counts around the limit
    for (int l = 1; l < 16; l++)
      for (int t = 1; t < 16; t++)
        for (int m = 0; m < 8; m++) begin
          int dsel[4] = '{0, 2, 3, 255};
          int din = dsel[(l + t + m) % 4];
          int p = prim_of(l, t, 1'b1, 1'b0);
          string tg;
          if (p == 0 || m[p-1]) tg = "R7 primary";
          else if (((m & ~(1 << (p - 1))) & 7) == 0) tg = "R6 no route";
          else if (din + 1 >= 3) tg = "R6 limit";
          else tg = "R5 detour";
          run_one(l, t, 1'b1, 1'b0, 3'(m), din, 3, tg);
        end

    // Stall: decision held, second header waits (R8)
    @(negedge clk);
    local_addr = enc(1, 0); local_len = 3'd1;
    tgt_addr = enc(5, 0); tgt_len = 3'd3;
    leaf_msg = 0; local_is_leaf = 0; link_ok = 3'b111;
    detour_in = 8'd9; detour_limit = 8'd20;
    hdr_valid = 1'b1; dec_ready = 1'b0;
    @(negedge clk);
    check("R8 first held", {dec_valid, dec_exit, dec_purge, dec_detour},
          {1'b1, 2'd2, 1'b0, 8'd9});
    tgt_addr = enc(3, 0); tgt_len = 3'd2;
    check("R8 ready low", {hdr_ready, 11'd0}, {1'b0, 11'd0});
    @(negedge clk);
    @(negedge clk);
    check("R8 still held", {dec_valid, dec_exit, dec_purge, dec_detour},
          {1'b1, 2'd2, 1'b0, 8'd9});
    dec_ready = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    check("R8 second taken", {dec_valid, dec_exit, dec_purge, dec_detour},
          {1'b1, 2'd3, 1'b0, 8'd9});
    @(negedge clk);
    check("R8 drained", {dec_valid, hdr_ready, 10'd0}, {1'b0, 1'b1, 10'd0});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule